// File: doc/BRIEF.md
# Debug Register File with Aliased Slots

This block holds the debug registers that a core reaches through its move-to-debug-register and move-from-debug-register instructions. There are four breakpoint address registers, one status register and one control register. The instruction decoder presents one request at a time: a 4-bit register number, a direction, the write data and the core state for the access. That state is the current privilege level, whether the core runs in 64-bit mode, and the debug-extension enable bit from the control register CR4 (CR4.DE). One clock later the block returns a response. The response carries the read data, or an invalid-opcode fault, or a general-protection fault. On a successful write it also carries a request to serialize the pipeline.

Register numbers 4 and 5 behave in one of two ways, selected by the debug-extension enable bit. When the bit is clear they stand in for the status and control registers. When it is set they are reserved. Numbers 8 and above are never valid. Outside 64-bit mode, transfers are 32 bits wide: read results and stored values have their upper half cleared. The operand is always a general-purpose register, so the addressing-mode field that comes with the request plays no part in the access.

Top module: `dbgreg_file`

## Requirements
- R1: After reset all six registers read as zero, and resp_valid, fault_ud, fault_gp, serialize_req and resp_rdata are all zero.
- R2: Register numbers 0 to 3 (breakpoint addresses), 6 (status) and 7 (control) each hold their own 64-bit value. In 64-bit mode a write followed by a read returns that value.
- R3: With dbg_ext_en = 0, number 4 reads and writes the status register (number 6) and number 5 reads and writes the control register (number 7).
- R4: With dbg_ext_en = 1, an access to number 4 or 5 sets fault_ud. No register changes, and resp_rdata is zero.
- R5: Any access to numbers 8 to 15 sets fault_ud. No register changes, and resp_rdata is zero.
- R6: An access at a privilege level other than 0 sets fault_gp. No register changes, and resp_rdata is zero. When a number would also raise fault_ud, only fault_ud is set.
- R7: With mode64 = 0, bits 63:32 of a read result are zero.
- R8: With mode64 = 0, a write stores bits 31:0 of the data and clears bits 63:32 of the register.
- R9: serialize_req is high in the response to a non-faulting write, and low for reads and for faulting accesses.
- R10: The acc_mod field has no effect on any response or register value.
- R11: Each cycle with acc_valid high gives exactly one response, with resp_valid high one clock later. A cycle with acc_valid low changes no register and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write the register, 0 = read it |
| acc_index | input | 4 | Debug register number |
| acc_mod | input | 2 | Addressing-mode field of the encoding; has no effect |
| acc_wdata | input | 64 | Write data |
| cpl | input | 2 | Current privilege level |
| mode64 | input | 1 | Core runs in 64-bit mode |
| dbg_ext_en | input | 1 | Debug-extension enable bit (CR4.DE): numbers 4 and 5 become reserved |
| resp_valid | output | 1 | Response valid, one clock after the request |
| resp_rdata | output | 64 | Read data; zero for writes and faults |
| fault_ud | output | 1 | Invalid-opcode fault |
| fault_gp | output | 1 | General-protection fault |
| serialize_req | output | 1 | A write took effect; the pipeline must serialize |

## Verification
The bench covers numbers 4 and 5 with the enable bit in both states. A design that reversed the alias pairing, or never treated these numbers as reserved, would return the wrong register's value or miss the fault. It also sends requests that are both out of range and unprivileged, to pin down the fault priority, and it reads back after every faulting write to catch a register that was updated anyway. It mixes 32-bit and 64-bit transfers in both directions. This exposes a design that clears the upper half only on reads, or stores the full width of the data, and also one that takes a write while acc_valid is low.

// File: rtl/dbgreg_pkg.sv
// Package: shared types for the debug register file.
// Assumes a single access per cycle; carries the fault verdict between modules.
package dbgreg_pkg;

    // Outcome of decoding one access
    typedef struct packed {
        logic ud;   // invalid-opcode fault
        logic gp;   // general-protection fault
        logic ok;   // access proceeds
    } dbg_verdict_t;

endpackage

// File: rtl/dbgreg_decode.sv
// Module: dbgreg_decode
// Maps a debug register number to a storage slot and decides the fault.
// Slots 0..NUM_BP-1 are breakpoints; slot NUM_BP is status and slot NUM_BP+1
// is control. Assumes numbers NUM_BP, NUM_BP+1 form the alias pair and
// NUM_BP+2, NUM_BP+3 are the status and control registers themselves.
module dbgreg_decode
    import dbgreg_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int NUM_BP = 4,
    parameter int SLOT_W = 3
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        cpl,
    input  logic              ext_en,
    output logic [SLOT_W-1:0] slot,
    output dbg_verdict_t      verdict
);
    localparam int ALIAS_STAT = NUM_BP;
    localparam int ALIAS_CTRL = NUM_BP + 1;
    localparam int REAL_STAT  = NUM_BP + 2;
    localparam int REAL_CTRL  = NUM_BP + 3;
    localparam int SLOT_STAT  = NUM_BP;
    localparam int SLOT_CTRL  = NUM_BP + 1;

    logic bad_num;

    // Select the slot and flag numbers that are invalid in the current state
    always_comb begin
        slot    = '0;
        bad_num = 1'b0;
        if (idx < IDX_W'(NUM_BP)) begin
            slot = SLOT_W'(idx);
        end else if (idx == IDX_W'(ALIAS_STAT) || idx == IDX_W'(REAL_STAT)) begin
            slot    = SLOT_W'(SLOT_STAT);
            bad_num = ext_en && (idx == IDX_W'(ALIAS_STAT));
        end else if (idx == IDX_W'(ALIAS_CTRL) || idx == IDX_W'(REAL_CTRL)) begin
            slot    = SLOT_W'(SLOT_CTRL);
            bad_num = ext_en && (idx == IDX_W'(ALIAS_CTRL));
        end else begin
            bad_num = 1'b1;
        end
    end

    // Invalid-opcode outranks the privilege check
    always_comb begin
        verdict.ud = bad_num;
        verdict.gp = !bad_num && (cpl != 2'd0);
        verdict.ok = !verdict.ud && !verdict.gp;
    end

endmodule

// File: rtl/dbgreg_narrow.sv
// Module: dbgreg_narrow
// Passes a value at full width, or clears its upper half for 32-bit transfers.
// Assumes DATA_W is even.
module dbgreg_narrow #(
    parameter int DATA_W = 64
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int HALF_W = DATA_W / 2;

    // Clear the upper half unless the transfer is full width
    always_comb begin
        dout = din;
        if (!wide) dout[DATA_W-1:HALF_W] = '0;
    end

endmodule

// File: rtl/dbgreg_store.sv
// Module: dbgreg_store
// Holds one register per slot and gives a combinational read of any slot.
// Assumes at most one write per cycle; a slot number out of range reads zero.
module dbgreg_store #(
    parameter int DATA_W    = 64,
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] rslot,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Load this slot when the write targets it
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[s] <= '0;
            else if (we && wslot == SLOT_W'(s))
                regs[s] <= wdata;
        end
    end

    // Pick the addressed slot for reading
    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (rslot == SLOT_W'(s)) rdata = regs[s];
    end

endmodule

// File: rtl/dbgreg_file.sv
// Module: dbgreg_file (top)
// Debug register file: decodes a request, updates storage on a good write and
// returns a registered response one clock later. Assumes the requester holds
// the core state (privilege, mode, extension enable) steady for the request cycle.
module dbgreg_file
    import dbgreg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4,
    parameter int NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [IDX_W-1:0]  acc_index,
    input  logic [1:0]        acc_mod,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        cpl,
    input  logic              mode64,
    input  logic              dbg_ext_en,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              fault_ud,
    output logic              fault_gp,
    output logic              serialize_req
);
    localparam int NUM_SLOTS = NUM_BP + 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    logic [SLOT_W-1:0] slot;
    dbg_verdict_t      verdict;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] raw_rd;
    logic [DATA_W-1:0] fmt_rd;
    logic              do_write;
    logic              unused_mod;

    // The operand is always a register; the addressing field is dropped
    assign unused_mod = ^acc_mod;

    dbgreg_decode #(
        .IDX_W (IDX_W),
        .NUM_BP(NUM_BP),
        .SLOT_W(SLOT_W)
    ) i_decode (
        .idx    (acc_index),
        .cpl    (cpl),
        .ext_en (dbg_ext_en),
        .slot   (slot),
        .verdict(verdict)
    );

    dbgreg_narrow #(.DATA_W(DATA_W)) i_wr_narrow (
        .wide(mode64),
        .din (acc_wdata),
        .dout(wr_val)
    );

    assign do_write = acc_valid && acc_write && verdict.ok;

    dbgreg_store #(
        .DATA_W   (DATA_W),
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W)
    ) i_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (do_write),
        .wslot(slot),
        .wdata(wr_val),
        .rslot(slot),
        .rdata(raw_rd)
    );

    dbgreg_narrow #(.DATA_W(DATA_W)) i_rd_narrow (
        .wide(mode64),
        .din (raw_rd),
        .dout(fmt_rd)
    );

    // Register the response for the access seen this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            resp_rdata    <= '0;
            fault_ud      <= 1'b0;
            fault_gp      <= 1'b0;
            serialize_req <= 1'b0;
        end else begin
            resp_valid    <= acc_valid;
            fault_ud      <= acc_valid && verdict.ud;
            fault_gp      <= acc_valid && verdict.gp;
            serialize_req <= do_write;
            resp_rdata    <= (acc_valid && !acc_write && verdict.ok) ? fmt_rd : '0;
        end
    end

endmodule

// File: rtl/dbgreg_chk.sv
// Module: dbgreg_chk
// Checker for dbgreg_file, bound to every instance. Observes ports only.
module dbgreg_chk #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [IDX_W-1:0]  acc_index,
    input logic [1:0]        cpl,
    input logic              mode64,
    input logic              resp_valid,
    input logic [DATA_W-1:0] resp_rdata,
    input logic              fault_ud,
    input logic              fault_gp,
    input logic              serialize_req
);
    localparam int HALF_W = DATA_W / 2;

    a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);
    a_r6_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_ud && fault_gp));
    a_r6_gp_needs_priv: assert property (@(posedge clk) disable iff (!rst_n)
        fault_gp |-> $past(cpl) != 2'd0);
    a_r5_high_num_ud: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(acc_index) >= IDX_W'(8)) |-> fault_ud);
    a_r4_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ud || fault_gp) |-> resp_rdata == '0);
    a_r7_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !$past(mode64)) |-> resp_rdata[DATA_W-1:HALF_W] == '0);
    a_r9_ser_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        serialize_req |-> (resp_valid && !fault_ud && !fault_gp && $past(acc_write)));

endmodule

bind dbgreg_file dbgreg_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_index    (acc_index),
    .cpl          (cpl),
    .mode64       (mode64),
    .resp_valid   (resp_valid),
    .resp_rdata   (resp_rdata),
    .fault_ud     (fault_ud),
    .fault_gp     (fault_gp),
    .serialize_req(serialize_req)
);

// File: tb/test_dbgreg_file.sv
`timescale 1ns/1ps
module test_dbgreg_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_index = '0;
    logic [1:0]  acc_mod = '0;
    logic [63:0] acc_wdata = '0;
    logic [1:0]  cpl = '0;
    logic        mode64 = 1'b1;
    logic        dbg_ext_en = 1'b0;
    logic        resp_valid;
    logic [63:0] resp_rdata;
    logic        fault_ud;
    logic        fault_gp;
    logic        serialize_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic        ud;
        logic        gp;
        logic        ser;
        logic [63:0] rd;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model [8];

    always #4 clk = ~clk;

    dbgreg_file i_dbgreg_file (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_index(acc_index), .acc_mod(acc_mod), .acc_wdata(acc_wdata),
        .cpl(cpl), .mode64(mode64), .dbg_ext_en(dbg_ext_en),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .fault_ud(fault_ud),
        .fault_gp(fault_gp), .serialize_req(serialize_req)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: present one access and push the expected response
    task automatic do_acc(input bit wr, input int idx, input logic [63:0] wd,
                          input int pl, input bit m64, input bit de,
                          input int md, input string tag);
        exp_t e;
        int   eff;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_index = 4'(idx);
        acc_wdata = wd; cpl = 2'(pl); mode64 = m64; dbg_ext_en = de; acc_mod = 2'(md);
        e.tag = tag;
        e.ud  = (idx >= 8) || (de && (idx == 4 || idx == 5));
        e.gp  = !e.ud && (pl != 0);
        eff   = (idx == 4) ? 6 : (idx == 5) ? 7 : idx;
        e.ser = wr && !e.ud && !e.gp;
        e.rd  = '0;
        if (!e.ud && !e.gp) begin
            if (wr) model[eff] = m64 ? wd : {32'h0, wd[31:0]};
            else    e.rd = m64 ? model[eff] : {32'h0, model[eff][31:0]};
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
        end
    endtask

    // Monitor: compare each response against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected response", 64'(resp_valid), 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(resp_rdata == e.rd, e.tag, "rdata", resp_rdata, e.rd);
                check(fault_ud == e.ud, e.tag, "fault_ud", 64'(fault_ud), 64'(e.ud));
                check(fault_gp == e.gp, e.tag, "fault_gp", 64'(fault_gp), 64'(e.gp));
                check(serialize_req == e.ser, e.tag, "serialize_req",
                      64'(serialize_req), 64'(e.ser));
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        check({resp_valid, fault_ud, fault_gp, serialize_req} == 4'b0 && resp_rdata == '0,
              "R1", "reset outputs", resp_rdata, 64'h0);
        // R1: every register reads zero
        foreach (model[i]) if (i != 4 && i != 5) do_acc(0, i, 0, 0, 1, 0, 0, "R1");
        // R2 + R9: write distinct full-width values
        for (int i = 0; i < 8; i++)
            if (i != 4 && i != 5)
                do_acc(1, i, {32'hA5A50000 + 32'(i), 32'h1234_0000 | 32'(i * 17)}, 0, 1, 0, 0, "R9");
        for (int i = 0; i < 8; i++) if (i != 4 && i != 5) do_acc(0, i, 0, 0, 1, 0, 0, "R2");
        // R3: alias pair with extension off
        do_acc(0, 4, 0, 0, 1, 0, 0, "R3");
        do_acc(1, 5, 64'hC0DE_0000_BEEF_0007, 0, 1, 0, 0, "R3");
        do_acc(0, 7, 0, 0, 1, 0, 0, "R3");
        do_acc(1, 4, 64'h0000_6666_0000_6666, 0, 1, 0, 0, "R3");
        do_acc(0, 6, 0, 0, 1, 0, 0, "R3");
        // R4: alias pair reserved with extension on; storage untouched
        do_acc(0, 4, 0, 0, 1, 1, 0, "R4");
        do_acc(1, 5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1, 0, "R4");
        do_acc(1, 4, 64'h1111_1111_1111_1111, 0, 1, 1, 0, "R4");
        do_acc(0, 7, 0, 0, 1, 1, 0, "R4");
        do_acc(0, 6, 0, 0, 1, 1, 0, "R4");
        do_acc(0, 6, 0, 0, 1, 1, 0, "R4");
        // R5: numbers 8..15 fault
        for (int i = 8; i < 16; i++) do_acc(0, i, 0, 0, 1, 0, 0, "R5");
        do_acc(1, 12, 64'hDEAD, 0, 1, 0, 0, "R5");
        do_acc(0, 0, 0, 0, 1, 0, 0, "R5");
        // R6: privilege fault, and invalid opcode wins over it
        do_acc(1, 0, 64'hBAD0_BAD0_BAD0_BAD0, 3, 1, 0, 0, "R6");
        do_acc(0, 1, 0, 1, 1, 0, 0, "R6");
        do_acc(0, 9, 0, 2, 1, 0, 0, "R6");
        do_acc(0, 5, 0, 3, 1, 1, 0, "R6");
        do_acc(0, 0, 0, 0, 1, 0, 0, "R6");
        // R7: 32-bit read clears the upper half
        do_acc(0, 0, 0, 0, 0, 0, 0, "R7");
        do_acc(0, 7, 0, 0, 0, 0, 0, "R7");
        // R8: 32-bit write stores only the low half
        do_acc(1, 1, 64'hFEED_FACE_8765_4321, 0, 0, 0, 0, "R8");
        do_acc(0, 1, 0, 0, 1, 0, 0, "R8");
        // R10: addressing field has no effect
        do_acc(1, 2, 64'h0102_0304_0506_0708, 0, 1, 0, 0, "R10");
        do_acc(0, 2, 0, 0, 1, 0, 3, "R10");
        do_acc(1, 3, 64'h1020_3040_5060_7080, 0, 1, 0, 1, "R10");
        do_acc(0, 3, 0, 0, 1, 0, 2, "R10");
        // R11: a write with acc_valid low is dropped
        idle(1);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_index = 4'd0;
        acc_wdata = 64'h7777_7777_7777_7777; cpl = 2'd0; mode64 = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R11", "no response", 64'(resp_valid), 64'h0);
        do_acc(0, 0, 0, 0, 1, 0, 0, "R11");
        idle(4);
        check(sb.size() == 0, "R11", "pending responses", 64'(sb.size()), 64'h0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule